// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader with Image Checksum

This block drives a three-wire serial EEPROM organised as 16-bit words and fetches data from it on request. A host raises a one-cycle start together with a mode and an offset. In word mode the offset is a word address. In byte mode the offset counts bytes, and the block returns one half of the word that holds that byte. In checksum mode the block reads every word of the device in turn and reports their 16-bit wraparound sum. A single-cycle good pulse marks an image whose sum is zero.

Each transaction raises chip select first. It then sends a start bit, a two-bit read opcode and the address, all most significant bit first. Sixteen data bits are then clocked back from the device, and chip select drops to close the transaction. Every pin update is held for a programmable number of system clocks, so the serial rate can be matched to the device. A configuration input selects the smaller device (8 address bits, 256 words) or the larger one (10 address bits, 1024 words).

Top module: `mw_eeprom_reader`

## Requirements
- R1: Chip select rises before the first serial clock pulse of a transaction and falls only while the serial clock is low, after the last data bit; the serial clock never rises while chip select is low.
- R2: Each transaction sends, on successive serial clock rising edges, a start bit of 1, then the read opcode 1 followed by 0, then the address bits, most significant first.
- R3: With big_dev = 0 the address field is 8 bits (the low 8 bits of the word address); with big_dev = 1 it is 10 bits.
- R4: Each serial clock pulse is one rise step followed by one fall step, and data out never changes in the step that raises the clock. Data out gets its own update step only at the first bit of the opcode field, at the first bit of the address field, and where a bit differs from the one before it. A word transaction therefore takes 1 + N x HOLD_CYC clocks from the accepting edge to done, where N = 37 + the sum over header bits of (2, plus 1 when an update step is needed).
- R5: Sixteen data bits are sampled at the end of each falling-edge step and assembled most significant bit first. In word mode (mode = 2'b00) rdata is the addressed word.
- R6: In byte mode (mode = 2'b01) offset N reads word N/2 (offset bit 0 dropped). rdata[7:0] is the upper byte for odd N and the lower byte for even N, and rdata[15:8] is zero.
- R7: In checksum mode (mode = 2'b10) the block reads words 0 up to the last word in ascending order and returns their sum modulo 2^16 on rdata. image_good pulses together with done exactly when that sum is zero.
- R8: Successive changes of the serial pins are at least HOLD_CYC system clocks apart.
- R9: A start that arrives while a request is in progress is ignored, and so is a start in the same cycle as done.
- R10: done is a single-cycle pulse. During and after reset, chip select, serial clock, data out, done and image_good are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| mode | input | 2 | 00 word, 01 byte, 10 checksum (11 acts as word) |
| big_dev | input | 1 | 0: 8-bit address device, 1: 10-bit address device |
| offset | input | AW_LARGE+1 | Word address (word mode) or byte offset (byte mode) |
| rdata | output | DW | Word, zero-extended byte, or checksum |
| done | output | 1 | One-cycle completion pulse |
| image_good | output | 1 | Pulses with done when a checksum is zero |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Serial data to the EEPROM |
| ee_miso | input | 1 | Serial data from the EEPROM |

## Verification
A new request strobe can land in the same cycle as the completion pulse of the previous request. The bench provokes this by raising start exactly in the cycle where done is seen. It also raises start once in the middle of a transaction, with a different offset. Both strobes are judged as ignored when the returned word belongs to the first offset and no further chip select rise appears in the following cycles. The end-of-word hand-off inside checksum mode, where one word's completion and the next word's launch follow in consecutive cycles, is judged by the ascending address sequence the EEPROM model records and by the final sum.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [1:0] {
      MODE_WORD = 2'b00,
      MODE_BYTE = 2'b01,
      MODE_SUM  = 2'b10
   } mw_mode_e;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_SEL,
      PH_START_DO,
      PH_START_RISE,
      PH_START_FALL,
      PH_BIT_DO,
      PH_BIT_RISE,
      PH_BIT_FALL,
      PH_DAT_RISE,
      PH_DAT_FALL,
      PH_DESEL
   } mw_phase_e;

   typedef enum logic [1:0] {
      C_IDLE,
      C_RUN,
      C_DONE
   } mw_ctrl_e;

   localparam logic [1:0] MW_READ_OP = 2'b10;

endpackage

// File: rtl/mw_hold_timer.sv
module mw_hold_timer #(
   parameter int HOLD_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

   generate
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("mw_hold_timer: HOLD_CYC must be at least 1");
      end

      if (HOLD_CYC == 1) begin : g_single
         logic unused_load;
         assign unused_load = load ^ clk ^ rst_n;
         assign expired = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= CW'(HOLD_CYC - 1);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign expired = (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/mw_serial_seq.sv
module mw_serial_seq
   import mw_pkg::*;
#(
   parameter int AW_SMALL = 8,
   parameter int AW_LARGE = 10,
   parameter int DW       = 16,
   parameter int HOLD_CYC = 125
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic                big,
   input  logic [AW_LARGE-1:0] word_addr,
   output logic                idle,
   output logic                word_done,
   output logic [DW-1:0]       word_data,
   output logic                cs,
   output logic                sclk,
   output logic                mosi,
   input  logic                miso
);
   localparam int OPW = 2;
   localparam int HW  = OPW + AW_LARGE;
   localparam int BCW = $clog2(HW + 1);
   localparam int DCW = $clog2(DW + 1);
   localparam int GW  = $clog2(HOLD_CYC + 1);

   mw_phase_e          ph_q;
   logic [HW-1:0]      hdr_q;
   logic [BCW-1:0]     bidx_q;
   logic [DW-1:0]      dat_q;
   logic [DCW-1:0]     dcnt_q;
   logic [AW_LARGE-1:0] addr_field;
   logic [BCW-1:0]     last_bit;
   logic               expired;
   logic               step;
   logic               need_do;

   // address field packing: left-aligned so the shift register always
   // sends from its top bit
   generate
      if (AW_LARGE < AW_SMALL) begin : g_bad_aw
         $error("mw_serial_seq: AW_LARGE must not be below AW_SMALL");
      end
      if (AW_LARGE == AW_SMALL) begin : g_one_width
         assign addr_field = word_addr;
         assign last_bit   = BCW'(HW - 1);
      end else begin : g_two_width
         assign addr_field = big ? word_addr :
                             {word_addr[AW_SMALL-1:0], {(AW_LARGE-AW_SMALL){1'b0}}};
         assign last_bit   = big ? BCW'(HW - 1) : BCW'(OPW + AW_SMALL - 1);
      end
   endgenerate

   mw_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (step),
      .expired(expired)
   );

   assign step = (ph_q == PH_IDLE) ? go : expired;

   // next header bit needs its own data-out step at a field start or on change
   assign need_do = ((bidx_q + 1'b1) == BCW'(OPW)) || (hdr_q[HW-2] != mosi);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cs     <= 1'b0;
         sclk   <= 1'b0;
         mosi   <= 1'b0;
         hdr_q  <= '0;
         bidx_q <= '0;
         dat_q  <= '0;
         dcnt_q <= '0;
      end else if (step) begin
         case (ph_q)
            PH_IDLE: begin
               ph_q   <= PH_SEL;
               cs     <= 1'b1;
               sclk   <= 1'b0;
               mosi   <= 1'b0;
               hdr_q  <= {MW_READ_OP, addr_field};
               bidx_q <= '0;
               dcnt_q <= '0;
            end
            PH_SEL: begin
               ph_q <= PH_START_DO;
               mosi <= 1'b1;
            end
            PH_START_DO: begin
               ph_q <= PH_START_RISE;
               sclk <= 1'b1;
            end
            PH_START_RISE: begin
               ph_q <= PH_START_FALL;
               sclk <= 1'b0;
            end
            PH_START_FALL: begin
               ph_q <= PH_BIT_DO;
               mosi <= hdr_q[HW-1];
            end
            PH_BIT_DO: begin
               ph_q <= PH_BIT_RISE;
               sclk <= 1'b1;
            end
            PH_BIT_RISE: begin
               ph_q <= PH_BIT_FALL;
               sclk <= 1'b0;
            end
            PH_BIT_FALL: begin
               if (bidx_q == last_bit) begin
                  ph_q <= PH_DAT_RISE;
                  sclk <= 1'b1;
               end else begin
                  hdr_q  <= {hdr_q[HW-2:0], 1'b0};
                  bidx_q <= bidx_q + 1'b1;
                  if (need_do) begin
                     ph_q <= PH_BIT_DO;
                     mosi <= hdr_q[HW-2];
                  end else begin
                     ph_q <= PH_BIT_RISE;
                     sclk <= 1'b1;
                  end
               end
            end
            PH_DAT_RISE: begin
               ph_q <= PH_DAT_FALL;
               sclk <= 1'b0;
            end
            PH_DAT_FALL: begin
               dat_q  <= {dat_q[DW-2:0], miso};
               dcnt_q <= dcnt_q + 1'b1;
               if (dcnt_q == DCW'(DW - 1)) begin
                  ph_q <= PH_DESEL;
                  cs   <= 1'b0;
                  mosi <= 1'b0;
               end else begin
                  ph_q <= PH_DAT_RISE;
                  sclk <= 1'b1;
               end
            end
            PH_DESEL: begin
               ph_q <= PH_IDLE;
            end
            default: begin
               ph_q <= PH_IDLE;
               cs   <= 1'b0;
               sclk <= 1'b0;
               mosi <= 1'b0;
            end
         endcase
      end
   end

   assign idle      = (ph_q == PH_IDLE);
   assign word_done = (ph_q == PH_DESEL) && expired;
   assign word_data = dat_q;

   // pin spacing monitor
   logic [2:0]    pins_d;
   logic [GW-1:0] gap_q;
   logic          pin_chg;

   assign pin_chg = ({cs, sclk, mosi} != pins_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pins_d <= 3'b000;
         gap_q  <= GW'(HOLD_CYC);
      end else begin
         pins_d <= {cs, sclk, mosi};
         if (pin_chg) begin
            gap_q <= GW'(1);
         end else if (gap_q < GW'(HOLD_CYC)) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   assert_hold_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_chg |-> (gap_q >= GW'(HOLD_CYC)));

   assert_clk_needs_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> cs);

   assert_cs_drop_clk_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs) |-> !sclk);

   assert_do_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(mosi));

endmodule

// File: rtl/mw_req_ctrl.sv
module mw_req_ctrl
   import mw_pkg::*;
#(
   parameter int AW_SMALL = 8,
   parameter int AW_LARGE = 10,
   parameter int DW       = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          mode,
   input  logic                big_dev,
   input  logic [AW_LARGE:0]   offset,
   input  logic                seq_idle,
   input  logic                word_done,
   input  logic [DW-1:0]       word_data,
   output logic                go,
   output logic                big,
   output logic [AW_LARGE-1:0] word_addr,
   output logic [DW-1:0]       rdata,
   output logic                done,
   output logic                image_good
);
   localparam int HB = DW / 2;

   mw_ctrl_e            st_q;
   mw_mode_e            mode_q;
   logic [AW_LARGE:0]   off_q;
   logic [AW_LARGE-1:0] idx_q;
   logic [AW_LARGE-1:0] last_idx;
   logic [DW-1:0]       sum_q;
   logic [DW-1:0]       sum_nxt;
   logic [HB-1:0]       byte_sel;

   generate
      if ((DW % 2) != 0 || DW < 4) begin : g_bad_dw
         $error("mw_req_ctrl: DW must be even and at least 4");
      end
      if (AW_LARGE == AW_SMALL) begin : g_one_size
         assign last_idx = '1;
      end else begin : g_two_size
         assign last_idx = big ? '1 : AW_LARGE'((1 << AW_SMALL) - 1);
      end
   endgenerate

   always_comb begin
      case (mode_q)
         MODE_SUM:  word_addr = idx_q;
         MODE_BYTE: word_addr = off_q[AW_LARGE:1];
         default:   word_addr = off_q[AW_LARGE-1:0];
      endcase
   end

   assign sum_nxt  = sum_q + word_data;
   assign byte_sel = off_q[0] ? word_data[DW-1:HB] : word_data[HB-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= C_IDLE;
         mode_q     <= MODE_WORD;
         big        <= 1'b0;
         off_q      <= '0;
         idx_q      <= '0;
         sum_q      <= '0;
         go         <= 1'b0;
         rdata      <= '0;
         done       <= 1'b0;
         image_good <= 1'b0;
      end else begin
         go <= 1'b0;
         case (st_q)
            C_IDLE: begin
               if (start) begin
                  st_q   <= C_RUN;
                  mode_q <= (mode == 2'b11) ? MODE_WORD : mw_mode_e'(mode);
                  big    <= big_dev;
                  off_q  <= offset;
                  idx_q  <= '0;
                  sum_q  <= '0;
                  go     <= 1'b1;
               end
            end
            C_RUN: begin
               if (word_done) begin
                  case (mode_q)
                     MODE_SUM: begin
                        if (idx_q == last_idx) begin
                           st_q       <= C_DONE;
                           rdata      <= sum_nxt;
                           done       <= 1'b1;
                           image_good <= (sum_nxt == '0);
                        end else begin
                           sum_q <= sum_nxt;
                           idx_q <= idx_q + 1'b1;
                           go    <= 1'b1;
                        end
                     end
                     MODE_BYTE: begin
                        st_q  <= C_DONE;
                        rdata <= {{(DW-HB){1'b0}}, byte_sel};
                        done  <= 1'b1;
                     end
                     default: begin
                        st_q  <= C_DONE;
                        rdata <= word_data;
                        done  <= 1'b1;
                     end
                  endcase
               end
            end
            default: begin
               st_q       <= C_IDLE;
               done       <= 1'b0;
               image_good <= 1'b0;
            end
         endcase
      end
   end

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_good_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      image_good |-> done);

   assert_launch_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> seq_idle);

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader #(
   parameter int AW_SMALL = 8,
   parameter int AW_LARGE = 10,
   parameter int DW       = 16,
   parameter int HOLD_CYC = 125
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [1:0]          mode,
   input  logic                big_dev,
   input  logic [AW_LARGE:0]   offset,
   output logic [DW-1:0]       rdata,
   output logic                done,
   output logic                image_good,
   output logic                ee_cs,
   output logic                ee_sclk,
   output logic                ee_mosi,
   input  logic                ee_miso
);
   generate
      if (AW_SMALL < 1) begin : g_bad_small
         $error("mw_eeprom_reader: AW_SMALL must be at least 1");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("mw_eeprom_reader: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic                go;
   logic                big;
   logic [AW_LARGE-1:0] word_addr;
   logic                seq_idle;
   logic                word_done;
   logic [DW-1:0]       word_data;

   mw_req_ctrl #(
      .AW_SMALL(AW_SMALL), .AW_LARGE(AW_LARGE), .DW(DW)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode      (mode),
      .big_dev   (big_dev),
      .offset    (offset),
      .seq_idle  (seq_idle),
      .word_done (word_done),
      .word_data (word_data),
      .go        (go),
      .big       (big),
      .word_addr (word_addr),
      .rdata     (rdata),
      .done      (done),
      .image_good(image_good)
   );

   mw_serial_seq #(
      .AW_SMALL(AW_SMALL), .AW_LARGE(AW_LARGE), .DW(DW), .HOLD_CYC(HOLD_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .big      (big),
      .word_addr(word_addr),
      .idle     (seq_idle),
      .word_done(word_done),
      .word_data(word_data),
      .cs       (ee_cs),
      .sclk     (ee_sclk),
      .mosi     (ee_mosi),
      .miso     (ee_miso)
   );
endmodule

// File: tb/mw_eeprom_reader_tb.sv
module mw_eeprom_reader_tb_top;
   localparam int AWS  = 8;
   localparam int AWL  = 10;
   localparam int HOLD = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        big_dev = 1'b0;
   logic [AWL:0] offset = '0;
   logic [15:0] rdata;
   logic        done, image_good;
   logic        ee_cs, ee_sclk, ee_mosi;
   logic        ee_miso = 1'b0;

   always #4 clk = ~clk;

   mw_eeprom_reader #(
      .AW_SMALL(AWS), .AW_LARGE(AWL), .DW(16), .HOLD_CYC(HOLD)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .big_dev(big_dev),
      .offset(offset), .rdata(rdata), .done(done), .image_good(image_good),
      .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   // EEPROM model
   logic [15:0] mem [0:1023];
   int sl_phase = 0, sl_cnt = 0, sl_addr = 0, sl_opc = 0, cur_aw = 8;
   int last_opc = 0, txn_cnt = 0;
   logic [15:0] sl_word = '0;
   int seen_addr[$];

   always @(posedge ee_cs) begin
      sl_phase = 0; sl_cnt = 0; sl_addr = 0; sl_opc = 0;
      txn_cnt++;
   end

   always @(posedge ee_sclk) begin
      if (ee_cs) begin
         case (sl_phase)
            0: if (ee_mosi) begin sl_phase = 1; sl_cnt = 0; end
            1: begin
               if (sl_cnt < 2) sl_opc = sl_opc * 2 + int'(ee_mosi);
               else            sl_addr = sl_addr * 2 + int'(ee_mosi);
               sl_cnt++;
               if (sl_cnt == 2 + cur_aw) begin
                  sl_phase = 2; sl_cnt = 0;
                  seen_addr.push_back(sl_addr);
                  last_opc = sl_opc;
                  sl_word  = mem[sl_addr];
               end
            end
            default: begin
               if (sl_cnt < 16) ee_miso <= sl_word[15 - sl_cnt];
               sl_cnt++;
            end
         endcase
      end
   end

   // per-clock protocol reference
   logic [2:0] pins_prev = 3'b000;
   int gap = 0;
   bit had_chg = 0;
   int err_r1 = 0, err_r4 = 0, err_r8 = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         gap++;
         if ({ee_cs, ee_sclk, ee_mosi} != pins_prev) begin
            if (had_chg && gap < HOLD) err_r8++;
            gap = 0; had_chg = 1;
         end
         if (ee_sclk && !pins_prev[1]) begin
            if (!ee_cs) err_r1++;
            if (ee_mosi != pins_prev[0]) err_r4++;
         end
         if (!ee_cs && pins_prev[2] && ee_sclk) err_r1++;
         pins_prev = {ee_cs, ee_sclk, ee_mosi};
      end
   end

   function automatic int exp_lat(input bit b, input int waddr);
      int aw = b ? AWL : AWS;
      int nb = 2 + aw;
      int bits[12];
      int n = 37;
      bits[0] = 1; bits[1] = 0;
      for (int i = 0; i < aw; i++) bits[2 + i] = (waddr >> (aw - 1 - i)) & 1;
      for (int i = 0; i < nb; i++) begin
         n += 2;
         if (i == 0 || i == 2 || bits[i] != bits[i - 1]) n += 1;
      end
      return 1 + n * HOLD;
   endfunction

   int done_pulse_err = 0;

   task automatic run(input logic [1:0] m, input bit b, input int off,
                      input bit poke_mid, input bit poke_done,
                      output logic [15:0] d, output logic g, output int lat);
      @(negedge clk);
      mode = m; big_dev = b; offset = off[AWL:0]; cur_aw = b ? AWL : AWS;
      start = 1'b1;
      @(posedge clk);
      lat = 0;
      @(negedge clk);
      start = 1'b0;
      while (!done) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         start = (poke_mid && lat == 20);
         if (poke_mid && lat == 20) begin
            offset = ~off[AWL:0]; mode = 2'b00;
         end
      end
      d = rdata; g = image_good;
      if (poke_done) begin
         start = 1'b1; offset = 11'h155; mode = 2'b00;
      end
      @(negedge clk);
      start = 1'b0;
      if (done) done_pulse_err++;
   endtask

   logic [15:0] d;
   logic g;
   int lat;
   int t0;
   logic [15:0] s;
   int bad_seq;

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503) ^ 16'h5A3C;
      s = 16'h0;
      for (int i = 0; i < 255; i++) s = s + mem[i];
      mem[255] = 16'h0 - s;

      repeat (4) @(negedge clk);
      check(!ee_cs && !ee_sclk && !ee_mosi && !done && !image_good, "R10 reset",
            {ee_cs, ee_sclk, ee_mosi, done, image_good}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!ee_cs && !done, "R10 after reset", {ee_cs, done}, 0);

      // word reads, large device
      run(2'b00, 1, 1023, 0, 0, d, g, lat);
      check(d == mem[1023], "R5 word 1023", d, mem[1023]);
      check(last_opc == 2, "R2 opcode", last_opc, 2);
      check(seen_addr[$] == 1023, "R3 addr 10b", seen_addr[$], 1023);
      check(lat == exp_lat(1, 1023), "R4 latency 1023", lat, exp_lat(1, 1023));

      run(2'b00, 1, 'h2A5, 0, 0, d, g, lat);
      check(d == mem['h2A5], "R5 word 2A5", d, mem['h2A5]);
      check(lat == exp_lat(1, 'h2A5), "R4 latency 2A5", lat, exp_lat(1, 'h2A5));

      run(2'b00, 1, 0, 0, 0, d, g, lat);
      check(d == mem[0], "R5 word 0", d, mem[0]);
      check(lat == exp_lat(1, 0), "R4 latency 0", lat, exp_lat(1, 0));

      // small device, high offset bits dropped
      run(2'b00, 0, 'h3C7, 0, 0, d, g, lat);
      check(seen_addr[$] == 'hC7, "R3 addr 8b", seen_addr[$], 'hC7);
      check(d == mem['hC7], "R5 word small", d, mem['hC7]);
      check(lat == exp_lat(0, 'hC7), "R4 latency small", lat, exp_lat(0, 'hC7));

      // byte reads
      run(2'b01, 1, 'h2B3, 0, 0, d, g, lat);
      check(d == {8'h00, mem['h159][15:8]}, "R6 odd byte", d, {8'h00, mem['h159][15:8]});
      check(seen_addr[$] == 'h159, "R6 byte word addr", seen_addr[$], 'h159);
      run(2'b01, 1, 'h2B2, 0, 0, d, g, lat);
      check(d == {8'h00, mem['h159][7:0]}, "R6 even byte", d, {8'h00, mem['h159][7:0]});

      // start while busy, and start in the done cycle
      t0 = txn_cnt;
      run(2'b00, 1, 'h0F0, 1, 1, d, g, lat);
      check(d == mem['h0F0], "R9 mid-run start ignored", d, mem['h0F0]);
      repeat (60) @(negedge clk);
      check(txn_cnt == t0 + 1, "R9 single transaction", txn_cnt - t0, 1);
      check(!ee_cs, "R9 no new select", ee_cs, 0);

      // checksum good
      seen_addr.delete();
      run(2'b10, 0, 0, 0, 0, d, g, lat);
      check(d == 16'h0, "R7 good sum", d, 0);
      check(g == 1'b1, "R7 good flag", g, 1);
      bad_seq = 0;
      foreach (seen_addr[i]) if (seen_addr[i] != i) bad_seq++;
      check(seen_addr.size() == 256 && bad_seq == 0, "R7 ascending reads",
            seen_addr.size(), 256);

      // checksum bad
      mem[17] = mem[17] ^ 16'h0100;
      s = 16'h0;
      for (int i = 0; i < 256; i++) s = s + mem[i];
      run(2'b10, 0, 0, 0, 0, d, g, lat);
      check(d == s, "R7 bad sum", d, s);
      check(g == 1'b0, "R7 bad flag", g, 0);

      check(done_pulse_err == 0, "R10 done single cycle", done_pulse_err, 0);
      check(err_r1 == 0, "R1 select framing", err_r1, 0);
      check(err_r4 == 0, "R4 data settled at rise", err_r4, 0);
      check(err_r8 == 0, "R8 pin hold spacing", err_r8, 0);

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got 0x%0h expected 0x%0h", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule